// File: doc/BRIEF.md
# Recirculating Longest-Prefix-Match Lookup Engine

This block finds the longest-prefix match for 32-bit IPv4 addresses in a three-level trie held in one synchronous memory with a single port. A lookup enters with a tag. Its first memory read is indexed by the top 16 address bits. Each word that comes back is either a leaf, which holds the result, or a pointer. When it is a pointer, the next 8-bit slice of the address is added to it and the request goes round the loop again. Many lookups can be in flight at once.

An internal FIFO holds the unused address bits, the trie level and the tag of every read that has not yet returned. The memory is therefore expected to answer in request order, but its latency may vary and it may apply backpressure. Results leave the engine tagged and may come out of order. A finishing lookup and a newly admitted one share the same cycle, so a stream of shallow lookups runs at one per cycle.

Top module: `lpm_loop_engine`

## Requirements
- R1: After reset, `res_valid_o` and `mem_req_valid_o` are low, and `req_ready_o` is high while `mem_req_ready_i` is high.
- R2: The first memory read of a lookup uses address bits 31:16 directly as the memory address.
- R3: A response word with bit 31 clear is a pointer. Its bits 15:0 plus the next slice (address bits 15:8 at the second level, bits 7:0 at the third) form the next memory address, wrapping modulo 2^16.
- R4: A response word with bit 31 set is a leaf. `res_value_o` is word bits 30:0 and `res_tag_o` is the lookup's tag, so a lookup makes 1, 2 or 3 memory reads.
- R5: A word returned at the third level is reported as the result whatever its bit 31.
- R6: In a cycle where a pointer response is consumed, no new request is admitted.
- R7: A leaf exit and a new admission can occur in the same cycle, so back-to-back single-read lookups complete one per cycle after the memory latency.
- R8: While `res_ready_i` is low, the offered result and tag stay stable. No lookup is lost or duplicated.
- R9: While `mem_req_ready_i` is low, no request is admitted. Memory backpressure loses no lookup.
- R10: Lookups of different depths may finish out of order. Each result carries the tag it entered with and the value of its own trie walk.
- R11: With FIFO depth D, at most D lookups are in flight. Once D reads are outstanding with no response, `req_ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted this cycle |
| req_addr_i | input | 32 | IPv4 address to look up |
| req_tag_i | input | TAG_W | Caller tag returned with the result |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | MEM_AW | Memory read address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_ready_o | output | 1 | Engine consumes the read data |
| mem_rsp_data_i | input | 32 | Trie word: bit 31 leaf flag, low bits value or pointer |
| res_valid_o | output | 1 | Lookup result valid |
| res_ready_i | input | 1 | Consumer takes the result |
| res_value_o | output | 31 | Leaf value |
| res_tag_o | output | TAG_W | Tag of the finished lookup |

## Verification
The assertions assume that the memory answers every accepted read exactly once and in request order. They also assume that it never presents data when no read is outstanding and that it holds a response unchanged until the engine takes it. The bench memory model is an in-order queue. It stamps each read with a due cycle and keeps its head response on the port until the engine takes it, so all of these conditions hold across latencies of 4 and 40 cycles and while the request-side ready toggles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ROOT_W  = 16;
  localparam int unsigned REST_W  = 16;
  localparam int unsigned SLICE_W = 8;
  localparam int unsigned VAL_W   = WORD_W - 1;

  typedef enum logic [1:0] {
    LVL_ROOT = 2'd0,
    LVL_MID  = 2'd1,
    LVL_LAST = 2'd2
  } lvl_e;
endpackage

// File: rtl/lpm_fifo.sv
module lpm_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic [WIDTH-1:0] enq_data_i,
  input  logic             deq_i,
  output logic             full_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] head_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign head_o  = slot_q[rd_q];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (enq_i && (wr_q == PW'(s))) slot_q[s] <= enq_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (enq_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (deq_i) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({enq_i, deq_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && full_o) |-> deq_i);
  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> valid_o);
endmodule

// File: rtl/lpm_stride.sv
module lpm_stride
  import lpm_pkg::*;
#(
  parameter int unsigned MEM_AW = 16
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [REST_W-1:0] rest_i,
  input  lvl_e              lvl_i,
  output logic              is_leaf_o,
  output logic [MEM_AW-1:0] next_addr_o,
  output logic [REST_W-1:0] next_rest_o,
  output lvl_e              next_lvl_o
);
  // third-level words terminate the walk regardless of the flag
  assign is_leaf_o   = word_i[WORD_W-1] | (lvl_i == LVL_LAST);
  assign next_addr_o = word_i[MEM_AW-1:0] + MEM_AW'(rest_i[REST_W-1 -: SLICE_W]);
  assign next_rest_o = {rest_i[REST_W-SLICE_W-1:0], {SLICE_W{1'b0}}};
  assign next_lvl_o  = (lvl_i == LVL_ROOT) ? LVL_MID : LVL_LAST;
endmodule

// File: rtl/lpm_loop_engine.sv
module lpm_loop_engine
  import lpm_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned MEM_AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_addr_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [MEM_AW-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [31:0]       mem_rsp_data_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [30:0]       res_value_o,
  output logic [TAG_W-1:0]  res_tag_o
);
  localparam int unsigned EW = TAG_W + REST_W + 2;

  logic          fifo_full, head_valid, enq, deq;
  logic [EW-1:0] head_q, enq_data;

  logic [TAG_W-1:0]  head_tag;
  logic [REST_W-1:0] head_rest, next_rest;
  lvl_e              head_lvl, next_lvl;
  logic              is_leaf;
  logic [MEM_AW-1:0] next_addr;

  assign head_tag  = head_q[EW-1 -: TAG_W];
  assign head_rest = head_q[REST_W+1:2];
  assign head_lvl  = lvl_e'(head_q[1:0]);

  lpm_stride #(.MEM_AW(MEM_AW)) i_stride (
    .word_i      (mem_rsp_data_i),
    .rest_i      (head_rest),
    .lvl_i       (head_lvl),
    .is_leaf_o   (is_leaf),
    .next_addr_o (next_addr),
    .next_rest_o (next_rest),
    .next_lvl_o  (next_lvl)
  );

  logic rsp_here, recirc_want, exit_want, exit_fire, recirc_fire;
  logic enter_room, enter_ok, enter_fire;

  assign rsp_here    = mem_rsp_valid_i & head_valid;
  assign recirc_want = rsp_here & ~is_leaf;
  assign exit_want   = rsp_here & is_leaf;
  assign exit_fire   = exit_want & res_ready_i;
  assign recirc_fire = recirc_want & mem_req_ready_i;

  // a leaving lookup frees its slot for a new one in the same cycle
  assign enter_room = ~fifo_full | exit_fire;
  assign enter_ok   = req_valid_i & ~recirc_want & enter_room;
  assign enter_fire = enter_ok & mem_req_ready_i;

  assign req_ready_o     = mem_req_ready_i & ~recirc_want & enter_room;
  assign mem_req_valid_o = recirc_want | enter_ok;
  assign mem_req_addr_o  = recirc_want ? next_addr : MEM_AW'(req_addr_i[31:16]);
  assign mem_rsp_ready_o = exit_fire | recirc_fire;

  assign res_valid_o = exit_want;
  assign res_value_o = mem_rsp_data_i[30:0];
  assign res_tag_o   = head_tag;

  assign enq      = enter_fire | recirc_fire;
  assign deq      = exit_fire | recirc_fire;
  assign enq_data = recirc_want ? {head_tag, next_rest, next_lvl}
                                : {req_tag_i, req_addr_i[15:0], LVL_ROOT};

  lpm_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) i_ctx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enq_i      (enq),
    .enq_data_i (enq_data),
    .deq_i      (deq),
    .full_o     (fifo_full),
    .valid_o    (head_valid),
    .head_o     (head_q)
  );

  // R6
  recirc_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_ready_o && !res_valid_o) |-> !(req_valid_i && req_ready_o));
  // R8
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_tag_o) && $stable(res_value_o)));
  // R10
  rsp_paired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> head_valid);
  // R9
  mem_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_ready_i |-> !req_ready_o);
endmodule

// File: tb/test_lpm_loop_engine.sv
module test_lpm_loop_engine;
  localparam int TAG_W = 4, DEPTH = 8, MEM_AW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic mem_req_valid_o, mem_req_ready_i = 1'b1;
  logic [MEM_AW-1:0] mem_req_addr_o;
  logic mem_rsp_valid_i, mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i;
  logic res_valid_o, res_ready_i = 1'b1;
  logic [30:0] res_value_o;
  logic [TAG_W-1:0] res_tag_o;

  always #5 clk_i = ~clk_i;

  lpm_loop_engine #(.TAG_W(TAG_W), .DEPTH(DEPTH), .MEM_AW(MEM_AW)) i_lpm_loop_engine (.*);

  int checks = 0, errors = 0;
  int cyc = 0, mem_lat = 4;
  logic [31:0] tbl [int];
  logic [31:0] q_data [64];
  int q_due [64];
  int q_rd = 0, q_wr = 0, q_cnt = 0;
  bit do_push = 0, do_pop = 0;
  int mem_acc = 0, acc = 0, rcv = 0, sent = 0;
  int prio_viol = 0, prio_seen = 0, overlap = 0;
  logic [15:0] alog [64];
  int alog_n = 0;
  logic [30:0] exp_val [16];
  bit pend [16];
  int first_tag = -1;

  function automatic logic [31:0] rd(int a);
    return tbl.exists(a) ? tbl[a] : 32'h8000_0000;
  endfunction

  function automatic logic [30:0] walk(logic [31:0] a, output int n);
    logic [31:0] w;
    w = rd(int'(a[31:16])); n = 1;
    if (w[31]) return w[30:0];
    w = rd(int'(16'(w[15:0] + 16'(a[15:8])))); n = 2;
    if (w[31]) return w[30:0];
    w = rd(int'(16'(w[15:0] + 16'(a[7:0])))); n = 3;
    return w[30:0];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  assign mem_rsp_valid_i = (q_cnt > 0) && (q_due[q_rd] <= cyc);
  assign mem_rsp_data_i  = q_data[q_rd];

  always @(posedge clk_i) begin
    if (do_push) begin
      q_data[q_wr] <= rd(int'(mem_req_addr_o));
      q_due[q_wr]  <= cyc + mem_lat;
      q_wr <= (q_wr + 1) % 64;
    end
    if (do_pop) q_rd <= (q_rd + 1) % 64;
    q_cnt <= q_cnt + int'(do_push) - int'(do_pop);
    cyc <= cyc + 1;
  end

  always @(negedge clk_i) begin
    do_push = rst_ni && mem_req_valid_o && mem_req_ready_i;
    do_pop  = rst_ni && mem_rsp_valid_i && mem_rsp_ready_o;
    if (do_push) begin
      mem_acc++;
      alog[alog_n % 64] = mem_req_addr_o;
      alog_n++;
    end
    if (rst_ni && req_valid_i && req_ready_o) acc++;
    if (rst_ni && mem_rsp_ready_o && !res_valid_o && req_valid_i) begin
      prio_seen++;
      if (req_ready_o) prio_viol++;
    end
    if (rst_ni && res_valid_o && res_ready_i) begin
      if (req_valid_i && req_ready_o) overlap++;
      if (first_tag < 0) first_tag = int'(res_tag_o);
      // R8: each lookup reported exactly once
      chk(pend[res_tag_o], "R8 unexpected or duplicate result tag", res_tag_o, 1);
      // R10: value matches this tag's own walk
      chk(res_value_o == exp_val[res_tag_o], "R10 result value for tag",
          res_value_o, exp_val[res_tag_o]);
      pend[res_tag_o] = 0;
      rcv++;
    end
  end

  task automatic send(logic [31:0] a, int tag);
    int n;
    bit ok;
    exp_val[tag] = walk(a, n);
    pend[tag] = 1;
    sent++;
    req_addr_i = a; req_tag_i = TAG_W'(tag); req_valid_i = 1'b1;
    do begin
      @(negedge clk_i); ok = req_ready_o;
      @(posedge clk_i); #1;
    end while (!ok);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (rcv != sent) @(negedge clk_i);
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(res_valid_o == 1'b0, "R1 res_valid after reset", res_valid_o, 0);
    chk(mem_req_valid_o == 1'b0, "R1 mem_req_valid after reset", mem_req_valid_o, 0);
    chk(req_ready_o == 1'b1, "R1 req_ready after reset", req_ready_o, 1);
    @(posedge clk_i); #1;
  endtask

  task automatic t_single(logic [31:0] a, int tag, int n_exp, logic [15:0] second, string req);
    int a0, n;
    logic [30:0] v;
    v = walk(a, n);
    a0 = mem_acc; alog_n = 0;
    send(a, tag);
    wait_idle();
    chk(mem_acc - a0 == n_exp, {req, " memory read count"}, mem_acc - a0, n_exp);
    chk(alog[0] == a[31:16], "R2 first read address", alog[0], a[31:16]);
    if (n_exp > 1) chk(alog[1] == second, "R3 second read address", alog[1], second);
    chk(v == exp_val[tag], {req, " model value"}, v, exp_val[tag]);
  endtask

  task automatic t_stream();
    int t0, ov0;
    t0 = cyc; ov0 = overlap;
    for (int k = 0; k < 12; k++) send(32'h0A00_0000 + k, k);
    wait_idle();
    // R7: one per cycle after the latency
    chk(cyc - t0 <= 12 + mem_lat + 2, "R7 stream duration", cyc - t0, 12 + mem_lat + 2);
    chk(overlap > ov0, "R7 exit and entry in one cycle", overlap - ov0, 1);
  endtask

  task automatic t_mixed();
    first_tag = -1;
    send(32'h0C00_3344, 0);
    send(32'h0A00_0001, 1);
    for (int k = 2; k < 10; k++)
      send((k % 3 == 0) ? 32'h0C00_3344 : (k % 3 == 1) ? 32'h0B00_2200 : 32'h0A00_0002, k);
    wait_idle();
    chk(first_tag == 1, "R10 shallow lookup overtakes deep one", first_tag, 1);
    chk(prio_seen > 0, "R6 recirculation met a waiting request", prio_seen, 1);
    chk(prio_viol == 0, "R6 admission during recirculation", prio_viol, 0);
  endtask

  task automatic t_stall();
    int r0;
    res_ready_i = 1'b0;
    for (int k = 0; k < 6; k++) send(32'h0B00_2200 + k, k);
    r0 = rcv;
    repeat (20) @(posedge clk_i);
    @(negedge clk_i);
    chk(rcv == r0, "R8 nothing taken while stalled", rcv, r0);
    chk(res_valid_o == 1'b1, "R8 result offered while stalled", res_valid_o, 1);
    @(posedge clk_i); #1;
    res_ready_i = 1'b1;
    wait_idle();
    chk(rcv == sent, "R8 all stalled results delivered", rcv, sent);
  endtask

  task automatic t_admit();
    int a0;
    mem_lat = 40; a0 = acc;
    fork
      for (int k = 0; k < 12; k++) send(32'h0A00_0000, k);
      begin
        repeat (25) @(negedge clk_i);
        chk(acc - a0 == DEPTH, "R11 in-flight limit", acc - a0, DEPTH);
      end
    join
    wait_idle();
    mem_lat = 4;
  endtask

  task automatic t_backpressure();
    req_addr_i = 32'h0A00_0000; req_tag_i = '0;
    mem_req_ready_i = 1'b0; req_valid_i = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b0, "R9 no admission without memory ready", req_ready_o, 0);
    @(posedge clk_i); #1;
    req_valid_i = 1'b0; mem_req_ready_i = 1'b1;
    fork
      for (int k = 0; k < 10; k++) send((k % 2) ? 32'h0C00_3345 : 32'h0D00_2000, k);
      for (int k = 0; k < 30; k++) begin
        @(posedge clk_i); #1;
        mem_req_ready_i = (k % 3 != 0);
      end
    join
    mem_req_ready_i = 1'b1;
    wait_idle();
    chk(rcv == sent, "R9 no lookup lost under backpressure", rcv, sent);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tbl[32'h0A00] = 32'h8000_0111;
    tbl[32'h0B00] = 32'h0000_1000;
    tbl[32'h1022] = 32'h8000_0222;
    tbl[32'h0C00] = 32'h0000_2000;
    tbl[32'h2033] = 32'h0000_3000;
    tbl[32'h3044] = 32'h8000_0333;
    tbl[32'h3045] = 32'h0000_0444;
    tbl[32'h0D00] = 32'h0000_FFF0;
    tbl[32'h0010] = 32'h8000_0555;
    for (int k = 0; k < 16; k++) pend[k] = 0;
    repeat (3) @(posedge clk_i); #1;
    rst_ni = 1'b1;
    t_reset();
    t_single(32'h0A00_1234, 1, 1, 16'h0, "R4 level-1 leaf");
    t_single(32'h0B00_22AA, 2, 2, 16'h1022, "R4 level-2 leaf");
    t_single(32'h0C00_3344, 3, 3, 16'h2033, "R4 level-3 leaf");
    t_single(32'h0C00_3345, 4, 3, 16'h2033, "R5 unflagged third-level word");
    t_single(32'h0D00_2000, 5, 2, 16'h0010, "R3 pointer wrap");
    t_single(32'h0E00_0000, 6, 1, 16'h0, "R4 absent entry");
    t_stream();
    t_mixed();
    t_stall();
    t_admit();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule